// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block is the system-control coprocessor of a small 32-bit processor. It holds the state that decides when normal execution stops and a handler starts:
- the saved return address,
- the last faulting data address,
- the interrupt mask and global enable,
- the nesting guard bit,
- the cause code,
- a free-running timer with a compare register.

The pipeline reads these registers through a register-number read port and writes them through a register-number write port.

Eight interrupt request lines and an exception request carrying a five-bit code feed the unit. In the same cycle that an exception arrives, or that an enabled interrupt is pending, the unit raises a redirect with the fixed handler address 0x80000180. In the next cycle it has saved the interrupted PC and set the nesting guard. A return request redirects to the saved address and clears the guard. Interrupt level 5 is also driven by the timer: it fires when the tick counter steps onto the compare value.

Decode, the pipeline and address translation are outside this block. All reads are combinational. All state changes happen on the rising clock edge. Reset is synchronous and active high.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, no redirect is raised, and the registers read as follows. Status reads 0x00000010. Cause reads only the live request lines in bits 15:8. EPC, BadVAddr, Count and Compare read 0.
- R2: The register numbers are BadVAddr 8, Count 9, Compare 11, Status 12, Cause 13 and EPC 14. Every other register number reads 0, and writes to those numbers have no effect.
- R3: The Status layout is as follows. Bits 15:8 are the per-level mask, where 1 means enabled. Bit 4 always reads 1. Bit 1 is the nesting guard (EXL). Bit 0 is the global enable. All other bits read 0, and writes to them are ignored.
- R4: Cause bits 15:8 show the pending levels, whatever the mask holds. Each level is its request line, and level 5 is ORed with the timer flag. Cause bits 6:2 hold the exception code. A software write changes only bits 6:2.
- R5: An interrupt is taken when all of these hold: global enable is 1, EXL is 0, the AND of pending and mask is nonzero, and no exception is requested. In that cycle the unit redirects to 0x80000180. In the next cycle EPC equals the victim PC, EXL is 1 and the code is 0.
- R6: An exception request always redirects to 0x80000180 in the same cycle and has priority over an interrupt. In the next cycle the code equals the requested code and EXL is 1. If EXL was 0, EPC is also loaded with the victim PC.
- R7: While EXL is 1, no interrupt is taken. An exception still redirects and updates the code, but EPC keeps its value.
- R8: A return request with no exception or interrupt being taken redirects to the current EPC in the same cycle. EXL reads 0 from the next cycle.
- R9: On an exception whose faulting-address valid input is 1, BadVAddr loads the faulting address. Software writes to BadVAddr are ignored.
- R10: Count increases by one every TICK_CYCLES clocks, counted from the end of reset. A software write loads Count instead of incrementing it in that cycle, and does not restart the tick spacing.
- R11: A tick that moves Count onto the value of Compare sets the timer flag, which is Cause bit 13. The flag stays set until Compare is written, and a Compare write clears it.
- R12: When a hardware event and a software write hit the same field in the same cycle, the hardware value wins. This covers EXL (set on entry, cleared on return), EPC and the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 5 | Register number to write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 5 | Register number to read |
| reg_rd_data | output | 32 | Combinational read data |
| irq_in | input | 8 | Interrupt request lines, one per level |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Exception code of the request |
| victim_pc | input | 32 | Address of the instruction about to execute |
| fault_addr_vld | input | 1 | Faulting data address is valid |
| fault_addr | input | 32 | Faulting data address |
| eret_req | input | 1 | Exception return request |
| redirect_vld | output | 1 | Pipeline must load redirect_pc |
| redirect_pc | output | 32 | Handler vector or return target |

## Verification
Two situations are hard to reach from the ports.

The first is the timer flag. It needs Count and Compare to line up on a tick edge while the tick phase is hidden. The stimulus loads Count and Compare two steps apart and then idles through several tick periods. The bench model tracks the tick phase from reset, so it knows the exact cycle in which Cause bit 13 rises and, once the level is unmasked, the cycle in which the redirect follows.

The second is same-cycle conflicts: a software write against entry or return, an exception against an interrupt, and an exception arriving while EXL is set. Each of these is driven as a directed cycle. A long pseudo-random phase follows, and it mixes all inputs at low rates.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int NLVL   = 8;
    localparam int CODE_W = 5;
    localparam int SEL_W  = 5;
    localparam int TIMER_LVL = 5;

    localparam logic [SEL_W-1:0] SEL_BADADDR = 5'd8;
    localparam logic [SEL_W-1:0] SEL_COUNT   = 5'd9;
    localparam logic [SEL_W-1:0] SEL_COMPARE = 5'd11;
    localparam logic [SEL_W-1:0] SEL_STATUS  = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE   = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC     = 5'd14;

    localparam logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180;

    typedef struct packed {
        logic [NLVL-1:0] mask;
        logic            exl;
        logic            ie;
    } status_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_EXC,
        ACT_IRQ,
        ACT_RET
    } action_e;

    function automatic logic [XLEN-1:0] pack_status(status_t s);
        return {16'h0000, s.mask, 3'b000, 1'b1, 2'b00, s.exl, s.ie};
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(logic [NLVL-1:0] pend,
                                                   logic [CODE_W-1:0] code);
        return {16'h0000, pend, 1'b0, code, 2'b00};
    endfunction

    function automatic logic is_entry(action_e a);
        return (a == ACT_EXC) || (a == ACT_IRQ);
    endfunction
endpackage

// File: rtl/exc_timer.sv
module exc_timer
    import exc_pkg::*;
#(
    parameter int TICK_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_we,
    input  logic            cmp_we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] count_q,
    output logic [XLEN-1:0] compare_q,
    output logic            flag_q
);
    localparam int PS_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_CYCLES - 1);

    logic [PS_W-1:0] ps_q;
    logic            tick;
    logic [XLEN-1:0] count_inc;

    assign tick      = (ps_q == PS_LAST);
    assign count_inc = count_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       ps_q <= '0;
        else if (tick) ps_q <= '0;
        else           ps_q <= ps_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         count_q <= '0;
        else if (cnt_we) count_q <= wdata;
        else if (tick)   count_q <= count_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)         compare_q <= '0;
        else if (cmp_we) compare_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (cmp_we)
            flag_q <= 1'b0;
        else if (tick && !cnt_we && (count_inc == compare_q))
            flag_q <= 1'b1;
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic            exc_req,
    input  logic            eret_req,
    input  status_t         st,
    input  logic [NLVL-1:0] pend,
    input  logic [XLEN-1:0] epc,
    output action_e         act,
    output logic            redirect_vld,
    output logic [XLEN-1:0] redirect_pc
);
    logic irq_ok;

    assign irq_ok = st.ie && !st.exl && (|(pend & st.mask));

    always_comb begin
        if (exc_req)       act = ACT_EXC;
        else if (irq_ok)   act = ACT_IRQ;
        else if (eret_req) act = ACT_RET;
        else               act = ACT_NONE;
    end

    always_comb begin
        redirect_vld = (act != ACT_NONE);
        redirect_pc  = (act == ACT_RET) ? epc : HANDLER_VEC;
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  action_e           act,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   victim_pc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              fault_addr_vld,
    input  logic [XLEN-1:0]   fault_addr,
    output status_t           st_q,
    output logic [CODE_W-1:0] code_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   badaddr_q
);
    logic entry;

    assign entry = is_entry(act);

    // Status: the software write lands first, the hardware update overrides EXL.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_STATUS) begin
                st_q.mask <= wr_data[15:8];
                st_q.exl  <= wr_data[1];
                st_q.ie   <= wr_data[0];
            end
            if (entry)               st_q.exl <= 1'b1;
            else if (act == ACT_RET) st_q.exl <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_CAUSE) code_q <= wr_data[6:2];
            if (entry) code_q <= (act == ACT_EXC) ? exc_code : '0;
        end
    end

    // EPC is frozen when the guard bit was already set before this entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_EPC) epc_q <= wr_data;
            if (entry && !st_q.exl)         epc_q <= victim_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            badaddr_q <= '0;
        else if (act == ACT_EXC && fault_addr_vld)
            badaddr_q <= fault_addr;
    end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int TICK_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic [SEL_W-1:0]      reg_wr_sel,
    input  logic [XLEN-1:0]       reg_wr_data,
    input  logic [SEL_W-1:0]      reg_rd_sel,
    output logic [XLEN-1:0]       reg_rd_data,
    input  logic [NLVL-1:0]       irq_in,
    input  logic                  exc_req,
    input  logic [CODE_W-1:0]     exc_code,
    input  logic [XLEN-1:0]       victim_pc,
    input  logic                  fault_addr_vld,
    input  logic [XLEN-1:0]       fault_addr,
    input  logic                  eret_req,
    output logic                  redirect_vld,
    output logic [XLEN-1:0]       redirect_pc
);
    status_t           st_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   badaddr_q;
    logic [XLEN-1:0]   count_q;
    logic [XLEN-1:0]   compare_q;
    logic              tmr_pend;
    logic              exl_q;
    logic [NLVL-1:0]   pend;
    action_e           act;

    assign exl_q = st_q.exl;

    for (genvar g = 0; g < NLVL; g++) begin : g_pend
        if (g == TIMER_LVL) begin : g_tmr
            assign pend[g] = irq_in[g] | tmr_pend;
        end else begin : g_hw
            assign pend[g] = irq_in[g];
        end
    end

    exc_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cnt_we    (reg_wr_en && reg_wr_sel == SEL_COUNT),
        .cmp_we    (reg_wr_en && reg_wr_sel == SEL_COMPARE),
        .wdata     (reg_wr_data),
        .count_q   (count_q),
        .compare_q (compare_q),
        .flag_q    (tmr_pend)
    );

    exc_arbiter u_arb (
        .exc_req      (exc_req),
        .eret_req     (eret_req),
        .st           (st_q),
        .pend         (pend),
        .epc          (epc_q),
        .act          (act),
        .redirect_vld (redirect_vld),
        .redirect_pc  (redirect_pc)
    );

    exc_state_regs u_regs (
        .clk            (clk),
        .rst            (rst),
        .act            (act),
        .wr_en          (reg_wr_en),
        .wr_sel         (reg_wr_sel),
        .wr_data        (reg_wr_data),
        .victim_pc      (victim_pc),
        .exc_code       (exc_code),
        .fault_addr_vld (fault_addr_vld),
        .fault_addr     (fault_addr),
        .st_q           (st_q),
        .code_q         (code_q),
        .epc_q          (epc_q),
        .badaddr_q      (badaddr_q)
    );

    always_comb begin
        case (reg_rd_sel)
            SEL_BADADDR: reg_rd_data = badaddr_q;
            SEL_COUNT:   reg_rd_data = count_q;
            SEL_COMPARE: reg_rd_data = compare_q;
            SEL_STATUS:  reg_rd_data = pack_status(st_q);
            SEL_CAUSE:   reg_rd_data = pack_cause(pend, code_q);
            SEL_EPC:     reg_rd_data = epc_q;
            default:     reg_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
    import exc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [SEL_W-1:0] reg_wr_sel,
    input logic [SEL_W-1:0] reg_rd_sel,
    input logic [XLEN-1:0]  reg_rd_data,
    input logic             exc_req,
    input logic             eret_req,
    input logic             redirect_vld,
    input logic [XLEN-1:0]  redirect_pc,
    input logic             exl_q,
    input logic [XLEN-1:0]  epc_q,
    input logic             tmr_pend
);
    a_r3_user_bit_reads_one: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_sel == SEL_STATUS) |-> reg_rd_data[4]);

    a_r6_exc_goes_to_vector: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (redirect_vld && redirect_pc == HANDLER_VEC));

    a_r6_exc_sets_guard: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> exl_q);

    a_r7_no_irq_while_guarded: assert property (@(posedge clk) disable iff (rst)
        (exl_q && !exc_req && !eret_req) |-> !redirect_vld);

    a_r7_epc_frozen: assert property (@(posedge clk) disable iff (rst)
        (exl_q && !(reg_wr_en && reg_wr_sel == SEL_EPC)) |=> $stable(epc_q));

    a_r8_return_clears_guard: assert property (@(posedge clk) disable iff (rst)
        (eret_req && exl_q && !exc_req) |=> !exl_q);

    a_r11_compare_write_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_sel == SEL_COMPARE) |=> !tmr_pend);
endmodule

bind exc_ctrl_unit exc_ctrl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_sel   (reg_wr_sel),
    .reg_rd_sel   (reg_rd_sel),
    .reg_rd_data  (reg_rd_data),
    .exc_req      (exc_req),
    .eret_req     (eret_req),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .exl_q        (exl_q),
    .epc_q        (epc_q),
    .tmr_pend     (tmr_pend)
);

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 4;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [4:0]  reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic [4:0]  reg_rd_sel;
    logic [31:0] reg_rd_data;
    logic [7:0]  irq_in;
    logic        exc_req;
    logic [4:0]  exc_code;
    logic [31:0] victim_pc;
    logic        fault_addr_vld;
    logic [31:0] fault_addr;
    logic        eret_req;
    logic        redirect_vld;
    logic [31:0] redirect_pc;

    exc_ctrl_unit #(.TICK_CYCLES(TICK)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .irq_in(irq_in), .exc_req(exc_req), .exc_code(exc_code), .victim_pc(victim_pc),
        .fault_addr_vld(fault_addr_vld), .fault_addr(fault_addr), .eret_req(eret_req),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string cur_tag  = "";

    // behavioural reference state
    logic [7:0]  m_mask;
    logic        m_exl, m_ie, m_tflag;
    logic [4:0]  m_code;
    logic [31:0] m_epc, m_bad, m_count, m_cmp;
    int          m_phase;

    task automatic model_reset();
        m_mask = '0; m_exl = 0; m_ie = 0; m_tflag = 0; m_code = '0;
        m_epc = '0; m_bad = '0; m_count = '0; m_cmp = '0; m_phase = 0;
    endtask

    function automatic logic [7:0] m_pend();
        logic [7:0] p;
        p = irq_in;
        p[5] = p[5] | m_tflag;
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] s);
        case (s)
            5'd8:  return m_bad;
            5'd9:  return m_count;
            5'd11: return m_cmp;
            5'd12: return {16'h0, m_mask, 3'b000, 1'b1, 2'b00, m_exl, m_ie};
            5'd13: return {16'h0, m_pend(), 1'b0, m_code, 2'b00};
            5'd14: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for_sel(input logic [4:0] s);
        case (s)
            5'd8:  return "R9";
            5'd9:  return "R10";
            5'd11: return "R11";
            5'd12: return "R3";
            5'd13: return "R4";
            5'd14: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_en = 0; reg_wr_sel = '0; reg_wr_data = '0;
        exc_req = 0; exc_code = '0; victim_pc = '0;
        fault_addr_vld = 0; fault_addr = '0; eret_req = 0;
    endtask

    // One clock: compare mid-cycle, then advance the model on the edge.
    task automatic step();
        logic take, ret, tick;
        logic [31:0] nxt;
        string t;
        #1;
        take = exc_req || (m_ie && !m_exl && (|(m_pend() & m_mask)));
        ret  = eret_req && !take;
        if (cur_tag != "")  t = cur_tag;
        else if (exc_req)   t = "R6";
        else if (eret_req)  t = "R8";
        else if (m_exl)     t = "R7";
        else                t = "R5";
        chk(t, "redirect_vld", {31'b0, redirect_vld}, {31'b0, take || ret});
        if (take || ret)
            chk(t, "redirect_pc", redirect_pc, take ? VEC : m_epc);
        chk(cur_tag != "" ? cur_tag : tag_for_sel(reg_rd_sel), "read data",
            reg_rd_data, m_read(reg_rd_sel));
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            tick = (m_phase == TICK - 1);
            m_phase = tick ? 0 : m_phase + 1;
            nxt = m_count + 1;
            if (reg_wr_en && reg_wr_sel == 5'd11) begin
                m_cmp = reg_wr_data; m_tflag = 0;
            end else if (tick && !(reg_wr_en && reg_wr_sel == 5'd9) && nxt == m_cmp) begin
                m_tflag = 1;
            end
            if (reg_wr_en && reg_wr_sel == 5'd9) m_count = reg_wr_data;
            else if (tick) m_count = nxt;
            if (take) begin
                if (!m_exl) m_epc = victim_pc;
                else if (reg_wr_en && reg_wr_sel == 5'd14) m_epc = reg_wr_data;
                if (reg_wr_en && reg_wr_sel == 5'd12) begin
                    m_mask = reg_wr_data[15:8]; m_ie = reg_wr_data[0];
                end
                m_exl  = 1;
                m_code = exc_req ? exc_code : 5'd0;
                if (exc_req && fault_addr_vld) m_bad = fault_addr;
            end else begin
                if (reg_wr_en && reg_wr_sel == 5'd14) m_epc = reg_wr_data;
                if (reg_wr_en && reg_wr_sel == 5'd13) m_code = reg_wr_data[6:2];
                if (reg_wr_en && reg_wr_sel == 5'd12) begin
                    m_mask = reg_wr_data[15:8]; m_ie = reg_wr_data[0];
                    m_exl = reg_wr_data[1];
                end
                if (ret) m_exl = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] s, input logic [31:0] d);
        reg_wr_en = 1; reg_wr_sel = s; reg_wr_data = d;
        step();
        idle();
    endtask

    task automatic watch(input logic [4:0] s, input int n);
        reg_rd_sel = s;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] sels [8] = '{5'd8, 5'd9, 5'd11, 5'd12, 5'd13, 5'd14, 5'd0, 5'd31};
        model_reset();
        idle();
        irq_in = '0;
        reg_rd_sel = 5'd12;
        rst = 1;
        @(posedge clk);
        @(negedge clk);

        // R1: reset state
        cur_tag = "R1";
        for (int i = 0; i < 8; i++) begin
            reg_rd_sel = sels[i];
            step();
        end
        rst = 0;
        for (int i = 0; i < 6; i++) begin
            reg_rd_sel = sels[i];
            step();
        end

        // R2: full register-number sweep, plus writes to unmapped numbers
        cur_tag = "R2";
        wr(5'd3, 32'hFFFF_FFFF);
        wr(5'd15, 32'h1234_5678);
        for (int s = 0; s < 32; s++) begin
            reg_rd_sel = 5'(s);
            step();
        end

        // R3: status layout, read-only bits
        cur_tag = "R3";
        reg_rd_sel = 5'd12;
        wr(5'd12, 32'hFFFF_FFEE);
        step();
        wr(5'd12, 32'h0000_0000);
        step();

        // R4: pending visible while masked, only the code field writable
        cur_tag = "R4";
        reg_rd_sel = 5'd13;
        irq_in = 8'hA1;
        step();
        wr(5'd13, 32'hFFFF_FFFF);
        step();
        wr(5'd13, 32'h0);
        irq_in = 8'h00;
        step();

        // R5: enabled interrupt taken, EPC captured
        cur_tag = "R5";
        wr(5'd12, 32'h0000_0401);
        irq_in = 8'h04;
        victim_pc = 32'h0000_0100;
        step();
        idle();
        watch(5'd14, 1);
        watch(5'd12, 1);

        // R7: guard bit blocks further interrupts
        cur_tag = "R7";
        watch(5'd13, 3);

        // R8: return to EPC, guard cleared
        cur_tag = "R8";
        irq_in = 8'h00;
        eret_req = 1;
        reg_rd_sel = 5'd12;
        step();
        idle();
        step();

        // R6: exception beats a pending enabled interrupt; R9 capture
        cur_tag = "R6";
        irq_in = 8'h04;
        exc_req = 1; exc_code = 5'd4; victim_pc = 32'h0000_0200;
        fault_addr_vld = 1; fault_addr = 32'hDEAD_BEE0;
        reg_rd_sel = 5'd13;
        step();
        idle();
        irq_in = 8'h00;
        watch(5'd13, 1);
        cur_tag = "R9";
        watch(5'd8, 1);
        wr(5'd8, 32'h0BAD_0BAD);
        watch(5'd8, 1);

        // R7: nested exception keeps EPC
        cur_tag = "R7";
        exc_req = 1; exc_code = 5'd5; victim_pc = 32'h0000_0300;
        reg_rd_sel = 5'd14;
        step();
        idle();
        watch(5'd14, 1);
        watch(5'd13, 1);
        eret_req = 1;
        step();
        idle();

        // R10: counter load and increment spacing
        cur_tag = "R10";
        wr(5'd9, 32'h0000_0010);
        watch(5'd9, 12);

        // R11: compare match raises level 5, compare write clears it
        cur_tag = "R11";
        wr(5'd12, 32'h0);
        wr(5'd9, 32'h0000_0050);
        wr(5'd11, 32'h0000_0052);
        watch(5'd13, 12);
        wr(5'd12, 32'h0000_2001);
        watch(5'd14, 2);
        eret_req = 1;
        wr(5'd11, 32'h0000_1000);
        watch(5'd13, 2);

        // R12: hardware update wins over a same-cycle software write
        cur_tag = "R12";
        wr(5'd12, 32'h0);
        reg_wr_en = 1; reg_wr_sel = 5'd14; reg_wr_data = 32'h0000_0777;
        exc_req = 1; exc_code = 5'd9; victim_pc = 32'h0000_0440;
        step();
        idle();
        watch(5'd14, 1);
        reg_wr_en = 1; reg_wr_sel = 5'd12; reg_wr_data = 32'h0000_0002;
        eret_req = 1;
        step();
        idle();
        watch(5'd12, 1);
        reg_wr_en = 1; reg_wr_sel = 5'd13; reg_wr_data = 32'h0000_007C;
        exc_req = 1; exc_code = 5'd2; victim_pc = 32'h0000_0500;
        step();
        idle();
        watch(5'd13, 1);
        eret_req = 1;
        step();
        idle();

        // mixed pseudo-random traffic
        cur_tag = "";
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            reg_rd_sel = sels[$urandom_range(0, 7)];
            irq_in = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            if (r < 8) begin
                reg_wr_en = 1;
                reg_wr_sel = sels[$urandom_range(0, 7)];
                reg_wr_data = (reg_wr_sel == 5'd11) ? m_count + 32'($urandom_range(1, 3))
                                                    : $urandom;
            end
            if (r >= 8 && r < 12) begin
                exc_req = 1; exc_code = 5'($urandom);
                victim_pc = $urandom; fault_addr_vld = $urandom_range(0, 1) == 1;
                fault_addr = $urandom;
            end
            if (r >= 12 && r < 18) eret_req = 1;
            victim_pc = (victim_pc == '0) ? 32'($urandom) : victim_pc;
            step();
            idle();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule